// File: doc/BRIEF.md
# Ring Token Expansion Controller

This block controls depth expansion for one FIFO that sits in a ring of identical FIFOs. The ring behaves as one deeper FIFO. Ownership of the write side and of the read side moves around the ring as a token. The token is an active-low pulse on an expansion output, and it is received on the next device's expansion input. The last device's output closes the ring back to the master. The memory, the pointers, the flag arithmetic and the data steering stay outside. This block receives "last location" indications from its own pointers and returns local write-active and read-active enables.

The role of the device is decided while reset is held. The role is master, slave or standalone, and it is taken from the two expansion inputs and a first-load strap. A master starts out owning both tokens. A slave owns neither. A standalone device always owns both sides. In standalone mode the write expansion output carries the externally supplied half-full flag, and the read expansion output is parked high.

Top module: `xp_ring_ctl`

## Requirements
- R1: On every rising clock edge while `rst_n` is low, each side latches its role from the straps. `wx_in_n`=0 and `rx_in_n`=0 select standalone. Otherwise `first_load`=1 selects master and `first_load`=0 selects slave.
- R2: At the first edge after reset release, a master has `wr_active`=1 and `rd_active`=1, a slave has both at 0, and both expansion outputs of a cascaded device are 1.
- R3: In cascaded mode, a rising `wclk` edge that sees `wr_active`=1, `wr_en`=1 and `wr_last`=1 clears `wr_active` and drives `wx_out_n` low for the following cycle.
- R4: In cascaded mode, `wx_out_n` is low for exactly one `wclk` cycle per token hand-off and is high at all other times.
- R5: In cascaded mode, a rising `wclk` edge that sees `wx_in_n`=0 sets `wr_active`.
- R6: While a cascaded device does not hold a token, `wr_en`/`wr_last` (or `rd_en`/`rd_last`) leave its active output at 0 and its expansion output at 1.
- R7: The read side follows the same hand-off rules as R3 to R6, using `rclk`, `rd_en`, `rd_last`, `rx_in_n`, `rx_out_n` and `rd_active`. It is independent of the write side.
- R8: In standalone mode, `wr_active` and `rd_active` are 1, `wx_out_n` equals `half_full_n`, and `rx_out_n` is 1, whatever the enables and expansion inputs do.
- R9: Strap changes after reset release do not change the latched role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| first_load | input | 1 | Strap: 1 selects master in a ring |
| wr_en | input | 1 | Write enable |
| wr_last | input | 1 | Write pointer is at the last physical location |
| rd_en | input | 1 | Read enable |
| rd_last | input | 1 | Read pointer is at the last physical location |
| wx_in_n | input | 1 | Write token input from the previous device (also a strap) |
| rx_in_n | input | 1 | Read token input from the previous device (also a strap) |
| half_full_n | input | 1 | Half-full flag routed to `wx_out_n` in standalone mode |
| wx_out_n | output | 1 | Write token output, or half-full flag when standalone |
| rx_out_n | output | 1 | Read token output, high when standalone |
| wr_active | output | 1 | Device currently owns writing |
| rd_active | output | 1 | Device currently owns reading |

## Verification
The bench resets the device three times, once with each strap pattern, and sees that the initial ownership tells master from slave from standalone. In each cascaded role it plays a streak of enables without the last-location mark, then the last-location mark, then enables with no token held, then an incoming token pulse. This separates a correct hand-off from one that fires early, fires twice or ignores the token. The read side is driven on its own phase-shifted clock at the same time, which exposes any coupling between the two sides. Toggling the half-full input and the straps after reset checks the standalone routing and that the role stays latched.

// File: rtl/xp_pkg.sv
`timescale 1ns/1ps
package xp_pkg;
   typedef enum logic [1:0] {
      XP_SOLO   = 2'd0,
      XP_MASTER = 2'd1,
      XP_SLAVE  = 2'd2
   } xp_role_e;

   function automatic xp_role_e xp_decode(input logic first_load,
                                          input logic wx_n,
                                          input logic rx_n);
      if (!wx_n && !rx_n) return XP_SOLO;
      else if (first_load) return XP_MASTER;
      else return XP_SLAVE;
   endfunction
endpackage

// File: rtl/xp_token_side.sv
`timescale 1ns/1ps
module xp_token_side
   import xp_pkg::*;
#(
   parameter int PULSE_LEN = 1
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     first_load,
   input  logic     strap_wx_n,
   input  logic     strap_rx_n,
   input  logic     en,
   input  logic     last_loc,
   input  logic     tok_in_n,
   input  logic     solo_level,
   output logic     tok_out_n,
   output logic     active,
   output xp_role_e role_o
);
   localparam int CW = $clog2(PULSE_LEN + 1);

   generate
      if (PULSE_LEN < 1) begin : g_bad_len
         $error("xp_token_side: PULSE_LEN must be at least 1");
      end
   endgenerate

   xp_role_e      role_q;
   logic          tok_q;
   logic [CW-1:0] cnt_q;
   logic          cascaded;
   logic          fire;
   logic          take;

   assign cascaded = (role_q != XP_SOLO);
   assign fire     = cascaded & tok_q & en & last_loc;
   assign take     = cascaded & ~tok_in_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         role_q <= xp_decode(first_load, strap_wx_n, strap_rx_n);
         tok_q  <= (xp_decode(first_load, strap_wx_n, strap_rx_n) == XP_MASTER);
         cnt_q  <= '0;
      end else begin
         tok_q <= (tok_q & ~fire) | take;
         if (fire)
            cnt_q <= CW'(PULSE_LEN);
         else if (cnt_q != '0)
            cnt_q <= cnt_q - CW'(1);
      end
   end

   assign tok_out_n = cascaded ? (cnt_q == '0) : solo_level;
   assign active    = ~cascaded | tok_q;
   assign role_o    = role_q;
endmodule

// File: rtl/xp_ring_ctl.sv
`timescale 1ns/1ps
module xp_ring_ctl
   import xp_pkg::*;
#(
   parameter int PULSE_LEN = 1
)(
   input  logic wclk,
   input  logic rclk,
   input  logic rst_n,
   input  logic first_load,
   input  logic wr_en,
   input  logic wr_last,
   input  logic rd_en,
   input  logic rd_last,
   input  logic wx_in_n,
   input  logic rx_in_n,
   input  logic half_full_n,
   output logic wx_out_n,
   output logic rx_out_n,
   output logic wr_active,
   output logic rd_active
);
   generate
      if (PULSE_LEN < 1 || PULSE_LEN > 255) begin : g_bad_cfg
         $error("xp_ring_ctl: PULSE_LEN out of range");
      end
   endgenerate

   xp_role_e wr_role;
   xp_role_e rd_role;

   xp_token_side #(.PULSE_LEN(PULSE_LEN)) u_wr (
      .clk(wclk), .rst_n(rst_n), .first_load(first_load),
      .strap_wx_n(wx_in_n), .strap_rx_n(rx_in_n),
      .en(wr_en), .last_loc(wr_last), .tok_in_n(wx_in_n),
      .solo_level(half_full_n), .tok_out_n(wx_out_n),
      .active(wr_active), .role_o(wr_role)
   );

   xp_token_side #(.PULSE_LEN(PULSE_LEN)) u_rd (
      .clk(rclk), .rst_n(rst_n), .first_load(first_load),
      .strap_wx_n(wx_in_n), .strap_rx_n(rx_in_n),
      .en(rd_en), .last_loc(rd_last), .tok_in_n(rx_in_n),
      .solo_level(1'b1), .tok_out_n(rx_out_n),
      .active(rd_active), .role_o(rd_role)
   );
endmodule

// File: rtl/xp_ring_ctl_chk.sv
`timescale 1ns/1ps
module xp_ring_ctl_chk
   import xp_pkg::*;
#(
   parameter int PULSE_LEN = 1
)(
   input logic     wclk,
   input logic     rclk,
   input logic     rst_n,
   input logic     wr_en,
   input logic     wr_last,
   input logic     rd_en,
   input logic     rd_last,
   input logic     wx_in_n,
   input logic     rx_in_n,
   input logic     half_full_n,
   input logic     wx_out_n,
   input logic     rx_out_n,
   input logic     wr_active,
   input logic     rd_active,
   input xp_role_e wr_role,
   input xp_role_e rd_role
);
   p_fire_r3: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_role != XP_SOLO && wr_active && wr_en && wr_last && wx_in_n)
      |=> (!wx_out_n && !wr_active));

   generate
      if (PULSE_LEN == 1) begin : g_one
         p_pulse_one_r4: assert property (@(posedge wclk) disable iff (!rst_n)
            (wr_role != XP_SOLO && !wx_out_n) |=> wx_out_n);
      end
   endgenerate

   p_take_r5: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_role != XP_SOLO && !wx_in_n) |=> wr_active);

   p_idle_r6: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_role != XP_SOLO && !wr_active && wx_in_n) |=> (!wr_active && wx_out_n));

   p_rd_fire_r7: assert property (@(posedge rclk) disable iff (!rst_n)
      (rd_role != XP_SOLO && rd_active && rd_en && rd_last && rx_in_n)
      |=> (!rx_out_n && !rd_active));

   p_rd_take_r7: assert property (@(posedge rclk) disable iff (!rst_n)
      (rd_role != XP_SOLO && !rx_in_n) |=> rd_active);

   p_solo_wr_r8: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_role == XP_SOLO) |-> (wr_active && (wx_out_n == half_full_n)));

   p_solo_rd_r8: assert property (@(posedge rclk) disable iff (!rst_n)
      (rd_role == XP_SOLO) |-> (rd_active && rx_out_n));

   p_role_hold_r9: assert property (@(posedge wclk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(wr_role));
endmodule

bind xp_ring_ctl xp_ring_ctl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (.*);

// File: tb/xp_ring_ctl_tb.sv
`timescale 1ns/1ps
module xp_ring_ctl_tb;
   logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
   logic first_load = 1'b1, wr_en = 1'b0, wr_last = 1'b0, rd_en = 1'b0, rd_last = 1'b0;
   logic wx_in_n = 1'b1, rx_in_n = 1'b1, half_full_n = 1'b1;
   logic wx_out_n, rx_out_n, wr_active, rd_active;

   int vectors = 0, miscompares = 0;
   string w_req = "R1 R2", r_req = "R1 R2";

   xp_ring_ctl u_dut (.*);

   always #5 wclk = ~wclk;
   initial begin #3; forever #5 rclk = ~rclk; end

   // behavioural reference: role 0 solo, 1 master, 2 slave
   int mw_role, mw_tok, mw_pulse, mr_role, mr_tok, mr_pulse;
   bit mw_ok = 0, mr_ok = 0;

   function automatic int ref_role();
      if (wx_in_n == 1'b0 && rx_in_n == 1'b0) return 0;
      return first_load ? 1 : 2;
   endfunction

   always @(posedge wclk) begin
      if (!rst_n) begin
         mw_role = ref_role(); mw_tok = (mw_role == 1); mw_pulse = 0; mw_ok = 1;
      end else if (mw_role != 0) begin
         if (mw_tok != 0 && wr_en && wr_last) begin mw_tok = 0; mw_pulse = 1; end
         else mw_pulse = 0;
         if (!wx_in_n) mw_tok = 1;
      end
   end

   always @(posedge rclk) begin
      if (!rst_n) begin
         mr_role = ref_role(); mr_tok = (mr_role == 1); mr_pulse = 0; mr_ok = 1;
      end else if (mr_role != 0) begin
         if (mr_tok != 0 && rd_en && rd_last) begin mr_tok = 0; mr_pulse = 1; end
         else mr_pulse = 0;
         if (!rx_in_n) mr_tok = 1;
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge wclk) if (rst_n && mw_ok) begin
      chk(w_req, "wr_active", wr_active, (mw_role == 0) ? 1'b1 : (mw_tok != 0));
      chk(w_req, "wx_out_n", wx_out_n, (mw_role == 0) ? half_full_n : (mw_pulse == 0));
   end

   always @(negedge rclk) if (rst_n && mr_ok) begin
      chk(r_req, "rd_active", rd_active, (mr_role == 0) ? 1'b1 : (mr_tok != 0));
      chk(r_req, "rx_out_n", rx_out_n, (mr_role == 0) ? 1'b1 : (mr_pulse == 0));
   end

   task automatic ws(int n); repeat (n) @(posedge wclk); #2; endtask
   task automatic rs(int n); repeat (n) @(posedge rclk); #2; endtask

   task automatic wr_ring_seq();
      w_req = "R2"; ws(2);
      w_req = "R3"; wr_en = 1; ws(3); wr_last = 1; ws(1); wr_last = 0;
      w_req = "R4"; ws(3);
      w_req = "R6"; wr_last = 1; ws(3); wr_en = 0; wr_last = 0;
      w_req = "R5"; wx_in_n = 0; ws(1); wx_in_n = 1;
      w_req = "R3"; wr_en = 1; wr_last = 1; ws(1); wr_en = 0; wr_last = 0;
      w_req = "R4"; ws(3);
   endtask

   task automatic rd_ring_seq();
      r_req = "R7"; rs(3); rd_en = 1; rd_last = 1; rs(1); rd_last = 0; rs(3);
      rd_last = 1; rs(2); rd_en = 0; rd_last = 0;
      rx_in_n = 0; rs(1); rx_in_n = 1; rs(1);
      rd_en = 1; rd_last = 1; rs(1); rd_en = 0; rd_last = 0; rs(3);
   endtask

   task automatic do_reset(logic fl, logic wx, logic rx);
      rst_n = 0; wr_en = 0; wr_last = 0; rd_en = 0; rd_last = 0;
      first_load = fl; wx_in_n = wx; rx_in_n = rx;
      w_req = "R1 R2"; r_req = "R1 R2";
      ws(3); rst_n = 1;
   endtask

   initial begin
      ws(1);
      // master
      do_reset(1'b1, 1'b1, 1'b1);
      fork wr_ring_seq(); rd_ring_seq(); join
      w_req = "R9"; r_req = "R9"; first_load = 0; ws(3);
      // slave
      do_reset(1'b0, 1'b1, 1'b1);
      fork wr_ring_seq(); rd_ring_seq(); join
      w_req = "R9"; r_req = "R9"; first_load = 1; ws(3);
      // standalone
      do_reset(1'b1, 1'b0, 1'b0);
      w_req = "R8"; r_req = "R8";
      wr_en = 1; wr_last = 1; rd_en = 1; rd_last = 1;
      for (int i = 0; i < 8; i++) begin half_full_n = i[0] ^ i[2]; ws(1); end
      wr_en = 0; wr_last = 0; rd_en = 0; rd_last = 0; ws(2);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #1000000;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule